// File: doc/BRIEF.md
# Two-Way MEI Data Cache Controller

This block runs an 8 KB physically addressed data cache built from two ways of 32-byte lines. Each line is held invalid, exclusive or modified, and never shared. This lets the cache sit on a bus beside caches that use the full four-state protocol: any foreign read or write that hits here takes the line away. The core side issues one 32-bit load or store at a time and holds the request until it is acknowledged. A hit answers in the same cycle. A miss first writes back a modified victim as a burst, then refills the line as a burst of `256/BUS_W` beats. An uncached access becomes one single-beat transfer and allocates nothing.

The system bus supplies snoops. A snoop that hits an exclusive line drops that line silently. A snoop that hits a modified line is told to retry. The dirty line is then pushed out as a burst write and invalidated. While the controller owns the bus, every snoop is told to retry. Each set keeps one bit that names the way to replace next. A free way is always filled before that bit is used.

Top module: `mei_dcache`

## Requirements
- R1: After reset every line is invalid, `core_ack`, `bus_req` and `snp_hit` are low, and the first cached read of any address causes a bus refill.
- R2: A cached miss issues a burst read (`bus_burst`=1, `bus_we`=0) of `256/BUS_W` beats (4 at the default width). The beats go to the ascending, line-aligned addresses `line + k*BUS_W/8`. Each beat's address is held until `bus_ack`. The requested word is then returned, including a word carried by the last beat.
- R3: A cached read or write that hits is acknowledged in the cycle it is presented, with no bus activity.
- R4: A write that hits an exclusive line updates the word and makes the line modified, with no bus activity. A later read returns the new word.
- R5: On a miss with both ways valid, the victim is the way not touched by the most recent hit or refill in that set. That way is evicted, and the other stays resident.
- R6: An exclusive victim is dropped without a bus write. A modified victim is first written back as a burst write of 4 beats carrying its data, before the refill burst starts.
- R7: A snoop that hits an exclusive line while the controller is idle gives `snp_hit`=1 and `snp_retry`=0. It invalidates the line with no bus transfer.
- R8: A snoop that hits a modified line while idle gives `snp_hit`=1 and `snp_retry`=1. It then causes a 4-beat burst write of the line, after which the line is invalid: a repeat snoop misses.
- R9: A snoop to an address not held gives `snp_hit`=0 and `snp_retry`=0.
- R10: A snoop that arrives while the controller owns the bus gets `snp_retry`=1 and `snp_hit`=0, and does not disturb the access in flight.
- R11: An uncached access issues exactly one non-burst beat (`bus_burst`=0) at the core address, with write data in bits 31:0 and read data taken from bits 31:0. It never allocates, so a repeat again goes to the bus.
- R12: When a snoop and a core request are presented in the same idle cycle, the snoop is handled first and the core is not acknowledged in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core access request, held until acknowledged |
| core_we | input | 1 | 1 = store, 0 = load |
| core_uncached | input | 1 | Access bypasses the cache |
| core_addr | input | ADDR_W | Byte address, word aligned |
| core_wdata | input | 32 | Store data |
| core_ack | output | 1 | Access completes at this clock edge |
| core_rdata | output | 32 | Load data, valid with `core_ack` |
| snp_valid | input | 1 | Snoop presented this cycle |
| snp_addr | input | ADDR_W | Snooped address |
| snp_hit | output | 1 | Snoop hits a valid line |
| snp_retry | output | 1 | Snooping master must retry |
| bus_req | output | 1 | Bus transfer beat requested |
| bus_we | output | 1 | Beat is a write |
| bus_burst | output | 1 | Beat belongs to a line burst |
| bus_addr | output | ADDR_W | Beat address |
| bus_wdata | output | BUS_W | Beat write data |
| bus_ack | input | 1 | Beat completes at this clock edge |
| bus_rdata | input | BUS_W | Beat read data |

## Verification
The hardest state to reach is a set whose resident victim is modified at the moment the set's replacement bit points at it. From there a single miss must produce a write-back followed by a refill. The stimulus gets there with three tags mapped to one set, plus a store and a series of hits that walk the replacement bit. This makes both the silent eviction and the write-back eviction happen, and the written-back word is then read again through a fresh refill. A snoop during a bus burst is reached by starting a miss in a forked thread and raising the snoop once `bus_req` is seen high.

// File: rtl/mei_dc_pkg.sv
package mei_dc_pkg;
   typedef enum logic [1:0] {
      LS_INV = 2'b00,
      LS_EXC = 2'b01,
      LS_MOD = 2'b10
   } line_st_e;

   typedef enum logic [1:0] {
      FS_IDLE,
      FS_UNC,
      FS_CAST,
      FS_FILL
   } fsm_e;
endpackage

// File: rtl/mei_dc_way.sv
module mei_dc_way
   import mei_dc_pkg::*;
#(
   parameter int TAG_W     = 20,
   parameter int IDX_W     = 7,
   parameter int LINE_BITS = 256
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic [TAG_W-1:0]     rd_tag,
   output line_st_e             rd_st,
   output logic [LINE_BITS-1:0] rd_line,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [TAG_W-1:0]     wr_tag,
   input  line_st_e             wr_st,
   input  logic [LINE_BITS-1:0] wr_line
);
   localparam int SETS = 1 << IDX_W;

   logic [TAG_W-1:0]     tag_q  [SETS];
   logic [LINE_BITS-1:0] line_q [SETS];
   line_st_e             st_q   [SETS];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         line_q[wr_idx] <= wr_line;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SETS; i++) st_q[i] <= LS_INV;
      end else if (wr_en) begin
         st_q[wr_idx] <= wr_st;
      end
   end

   assign rd_tag  = tag_q[rd_idx];
   assign rd_st   = st_q[rd_idx];
   assign rd_line = line_q[rd_idx];
endmodule

// File: rtl/mei_dc_lru.sv
module mei_dc_lru #(
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             victim,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             upd_way
);
   localparam int SETS = 1 << IDX_W;

   logic lru_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SETS; i++) lru_q[i] <= 1'b0;
      end else if (upd_en) begin
         lru_q[upd_idx] <= ~upd_way;
      end
   end

   assign victim = lru_q[rd_idx];

   // R5: the way just used is never the next victim of its set
   assert_lru_points_away_R5: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> (lru_q[$past(upd_idx)] != $past(upd_way)));
endmodule

// File: rtl/mei_dcache.sv
module mei_dcache
   import mei_dc_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CACHE_BYTES = 8192,
   parameter int LINE_BYTES  = 32,
   parameter int BUS_W       = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_req,
   input  logic              core_we,
   input  logic              core_uncached,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic [31:0]       core_wdata,
   output logic              core_ack,
   output logic [31:0]       core_rdata,
   input  logic              snp_valid,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_hit,
   output logic              snp_retry,
   output logic              bus_req,
   output logic              bus_we,
   output logic              bus_burst,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [BUS_W-1:0]  bus_wdata,
   input  logic              bus_ack,
   input  logic [BUS_W-1:0]  bus_rdata
);
   localparam int LINE_BITS = LINE_BYTES * 8;
   localparam int SETS      = CACHE_BYTES / (2 * LINE_BYTES);
   localparam int IDX_W     = $clog2(SETS);
   localparam int OFF_W     = $clog2(LINE_BYTES);
   localparam int TAG_W     = ADDR_W - IDX_W - OFF_W;
   localparam int BEATS     = LINE_BITS / BUS_W;
   localparam int BEAT_W    = $clog2(BEATS);
   localparam int BB_W      = $clog2(BUS_W / 8);
   localparam int WSEL_W    = $clog2(LINE_BITS / 32);

   generate
      if (!(BUS_W == 32 || BUS_W == 64)) begin : g_bad_bus
         $error("BUS_W must be 32 or 64");
      end
      if ((1 << IDX_W) != SETS || (1 << OFF_W) != LINE_BYTES) begin : g_bad_geom
         $error("cache and line sizes must be powers of two");
      end
      if (BEATS < 2) begin : g_bad_beats
         $error("a line must span at least two bus beats");
      end
   endgenerate

   fsm_e                  fsm_q;
   logic [ADDR_W-1:0]     op_addr_q;
   logic                  op_way_q;
   logic                  snp_co_q;
   logic [BEAT_W-1:0]     beat_q;
   logic [LINE_BITS-1:0]  fill_q;

   logic                  idle;
   logic [ADDR_W-1:0]     look_addr;
   logic [IDX_W-1:0]      look_idx;
   logic [TAG_W-1:0]      look_tag;
   logic [WSEL_W-1:0]     wsel;
   logic [TAG_W-1:0]      way_tag  [2];
   line_st_e              way_st   [2];
   logic [LINE_BITS-1:0]  way_line [2];
   logic [1:0]            hit_vec;
   logic                  hit_any, hit_way, lru_victim, victim;
   logic [LINE_BITS-1:0]  hit_line;
   logic                  snoop_go, core_go, cache_hit, last_beat, fill_done;
   logic                  wr_any, wr_way, upd_en, upd_way;
   line_st_e              wr_st;
   logic [LINE_BITS-1:0]  wr_line;
   logic [BUS_W-1:0]      unc_wdata;

   assign idle      = (fsm_q == FS_IDLE);
   assign look_addr = idle ? (snp_valid ? snp_addr : core_addr) : op_addr_q;
   assign look_idx  = look_addr[OFF_W +: IDX_W];
   assign look_tag  = look_addr[ADDR_W-1 -: TAG_W];
   assign wsel      = core_addr[2 +: WSEL_W];

   generate
      for (genvar w = 0; w < 2; w++) begin : g_way
         mei_dc_way #(.TAG_W(TAG_W), .IDX_W(IDX_W), .LINE_BITS(LINE_BITS)) u_way (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_idx  (look_idx),
            .rd_tag  (way_tag[w]),
            .rd_st   (way_st[w]),
            .rd_line (way_line[w]),
            .wr_en   (wr_any && (wr_way == 1'(w))),
            .wr_idx  (look_idx),
            .wr_tag  (look_tag),
            .wr_st   (wr_st),
            .wr_line (wr_line)
         );
         assign hit_vec[w] = (way_st[w] != LS_INV) && (way_tag[w] == look_tag);
      end

      if (BUS_W == 32) begin : g_unc_narrow
         assign unc_wdata = core_wdata;
      end else begin : g_unc_wide
         assign unc_wdata = {{(BUS_W-32){1'b0}}, core_wdata};
      end
   endgenerate

   mei_dc_lru #(.IDX_W(IDX_W)) u_lru (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (look_idx),
      .victim  (lru_victim),
      .upd_en  (upd_en),
      .upd_idx (look_idx),
      .upd_way (upd_way)
   );

   assign hit_any   = |hit_vec;
   assign hit_way   = hit_vec[1];
   assign hit_line  = way_line[hit_way];
   assign victim    = (way_st[0] == LS_INV) ? 1'b0 :
                      (way_st[1] == LS_INV) ? 1'b1 : lru_victim;
   assign snoop_go  = idle && snp_valid;
   assign core_go   = idle && !snp_valid && core_req;
   assign cache_hit = core_go && !core_uncached && hit_any;
   assign last_beat = (beat_q == BEAT_W'(BEATS - 1));
   assign fill_done = (fsm_q == FS_FILL) && bus_ack && last_beat;
   assign upd_en    = cache_hit || fill_done;
   assign upd_way   = cache_hit ? hit_way : op_way_q;

   assign snp_hit   = snoop_go && hit_any;
   assign snp_retry = snp_valid && (!idle || (hit_any && way_st[hit_way] == LS_MOD));
   assign core_ack  = cache_hit || ((fsm_q == FS_UNC) && bus_ack);
   assign core_rdata = (fsm_q == FS_UNC) ? bus_rdata[31:0] : hit_line[32*wsel +: 32];

   always_comb begin
      wr_any  = 1'b0;
      wr_way  = hit_way;
      wr_st   = LS_INV;
      wr_line = hit_line;
      if (cache_hit && core_we) begin
         wr_any = 1'b1;
         wr_st  = LS_MOD;
         wr_line[32*wsel +: 32] = core_wdata;
      end else if (snoop_go && hit_any && way_st[hit_way] == LS_EXC) begin
         wr_any = 1'b1;
      end else if (fill_done) begin
         wr_any  = 1'b1;
         wr_way  = op_way_q;
         wr_st   = LS_EXC;
         wr_line = fill_q;
         wr_line[(BEATS-1)*BUS_W +: BUS_W] = bus_rdata;
      end else if ((fsm_q == FS_CAST) && bus_ack && last_beat && snp_co_q) begin
         wr_any  = 1'b1;
         wr_way  = op_way_q;
         wr_line = way_line[op_way_q];
      end
   end

   assign bus_req   = !idle;
   assign bus_we    = (fsm_q == FS_CAST) || ((fsm_q == FS_UNC) && core_we);
   assign bus_burst = (fsm_q == FS_CAST) || (fsm_q == FS_FILL);

   always_comb begin
      unique case (fsm_q)
         FS_CAST: bus_addr = {way_tag[op_way_q], look_idx, beat_q, {BB_W{1'b0}}};
         FS_FILL: bus_addr = {op_addr_q[ADDR_W-1:OFF_W], beat_q, {BB_W{1'b0}}};
         default: bus_addr = op_addr_q;
      endcase
      bus_wdata = (fsm_q == FS_CAST) ? way_line[op_way_q][BUS_W*beat_q +: BUS_W] : unc_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsm_q     <= FS_IDLE;
         op_addr_q <= '0;
         op_way_q  <= 1'b0;
         snp_co_q  <= 1'b0;
         beat_q    <= '0;
      end else begin
         unique case (fsm_q)
            FS_IDLE: begin
               op_addr_q <= look_addr;
               beat_q    <= '0;
               if (snoop_go) begin
                  if (hit_any && way_st[hit_way] == LS_MOD) begin
                     op_way_q <= hit_way;
                     snp_co_q <= 1'b1;
                     fsm_q    <= FS_CAST;
                  end
               end else if (core_go && core_uncached) begin
                  fsm_q <= FS_UNC;
               end else if (core_go && !hit_any) begin
                  op_way_q <= victim;
                  snp_co_q <= 1'b0;
                  fsm_q    <= (way_st[victim] == LS_MOD) ? FS_CAST : FS_FILL;
               end
            end
            FS_UNC: if (bus_ack) fsm_q <= FS_IDLE;
            FS_CAST: if (bus_ack) begin
               beat_q <= beat_q + 1'b1;
               if (last_beat) fsm_q <= snp_co_q ? FS_IDLE : FS_FILL;
            end
            FS_FILL: if (bus_ack) begin
               beat_q <= beat_q + 1'b1;
               if (last_beat) fsm_q <= FS_IDLE;
            end
            default: fsm_q <= FS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (fsm_q == FS_FILL && bus_ack) fill_q[BUS_W*beat_q +: BUS_W] <= bus_rdata;
   end

   // R2: a beat's address is held until it is acknowledged
   assert_beat_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));

   // R3: a cached acknowledge never coincides with bus activity
   assert_hit_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (core_ack && !core_uncached) |-> !bus_req);

   // R10: snoops during bus ownership are retried and report no hit
   assert_busy_retry_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && bus_req) |-> (snp_retry && !snp_hit));

   // R11: a non-burst beat ends the transfer
   assert_unc_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack && !bus_burst) |=> !bus_req);

   // R8: a snoop hit with retry is followed by a burst write
   assert_snoop_castout_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_hit && snp_retry) |=> (bus_req && bus_we && bus_burst));
endmodule

// File: tb/mei_dcache_tb.sv
`timescale 1ns/1ps
module mei_dcache_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        core_req = 1'b0, core_we = 1'b0, core_uncached = 1'b0;
   logic [31:0] core_addr = '0, core_wdata = '0;
   logic        core_ack;
   logic [31:0] core_rdata;
   logic        snp_valid = 1'b0;
   logic [31:0] snp_addr = '0;
   logic        snp_hit, snp_retry;
   logic        bus_req, bus_we, bus_burst;
   logic [31:0] bus_addr;
   logic [63:0] bus_wdata;
   logic        bus_ack = 1'b0;
   logic [63:0] bus_rdata = '0;

   int checks = 0, failures = 0;
   int rd_beats = 0, wr_beats = 0, unc_beats = 0;
   bit done = 1'b0;
   logic [31:0] wm [logic [31:0]];

   always #2 clk = ~clk;

   mei_dcache u_dut (
      .clk(clk), .rst_n(rst_n),
      .core_req(core_req), .core_we(core_we), .core_uncached(core_uncached),
      .core_addr(core_addr), .core_wdata(core_wdata),
      .core_ack(core_ack), .core_rdata(core_rdata),
      .snp_valid(snp_valid), .snp_addr(snp_addr),
      .snp_hit(snp_hit), .snp_retry(snp_retry),
      .bus_req(bus_req), .bus_we(bus_we), .bus_burst(bus_burst),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   function automatic logic [31:0] memrd(input logic [31:0] a);
      return wm.exists(a) ? wm[a] : (a ^ 32'hC0DE_0000);
   endfunction

   // bus model: acknowledges every requested beat
   always @(negedge clk) begin
      bus_ack <= bus_req;
      if (bus_req) begin
         bus_rdata <= {memrd(bus_addr + 32'd4), memrd(bus_addr)};
         if (bus_burst && bus_we) begin
            wr_beats <= wr_beats + 1;
            wm[bus_addr]         = bus_wdata[31:0];
            wm[bus_addr + 32'd4] = bus_wdata[63:32];
         end else if (bus_burst) begin
            rd_beats <= rd_beats + 1;
         end else begin
            unc_beats <= unc_beats + 1;
            if (bus_we) wm[bus_addr] = bus_wdata[31:0];
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input logic [31:0] a, input bit we, input logic [31:0] wd,
                         input bit unc, output logic [31:0] rd);
      @(negedge clk);
      core_addr = a; core_we = we; core_wdata = wd; core_uncached = unc; core_req = 1'b1;
      #1;
      while (!core_ack) begin
         @(negedge clk); #1;
      end
      rd = core_rdata;
      @(posedge clk); #1 core_req = 1'b0;
   endtask

   task automatic snoop(input logic [31:0] a, input bit exp_hit, input bit exp_retry, input string req);
      @(negedge clk);
      snp_valid = 1'b1; snp_addr = a;
      #1;
      chk({req, " snp_hit"}, 32'(snp_hit), 32'(exp_hit));
      chk({req, " snp_retry"}, 32'(snp_retry), 32'(exp_retry));
      @(posedge clk); #1 snp_valid = 1'b0;
      @(negedge clk);
      while (bus_req) @(negedge clk);
      #1;
   endtask

   // read with expected data and expected bus beat deltas
   task automatic rd_exp(input logic [31:0] a, input logic [31:0] exp, input int drd,
                         input int dwr, input string req);
      logic [31:0] d;
      int r0 = rd_beats, w0 = wr_beats;
      access(a, 1'b0, '0, 1'b0, d);
      chk({req, " data"}, d, exp);
      chk({req, " fill beats"}, 32'(rd_beats - r0), 32'(drd));
      chk({req, " castout beats"}, 32'(wr_beats - w0), 32'(dwr));
   endtask

   localparam logic [31:0] A = 32'h0000_1040, B = 32'h0000_2040, C = 32'h0000_3040;

   task automatic t_reset;
      #1;
      chk("R1 core_ack after reset", 32'(core_ack), 0);
      chk("R1 bus_req after reset", 32'(bus_req), 0);
      chk("R1 snp_hit after reset", 32'(snp_hit), 0);
   endtask

   task automatic t_fill_and_hits;
      logic [31:0] d;
      int r0;
      rd_exp(A + 4, memrd(A + 4), 4, 0, "R1 R2 first read misses");
      rd_exp(A + 32'h1C, memrd(A + 32'h1C), 0, 0, "R3 R2 last-beat word hit");
      r0 = rd_beats;
      access(A + 4, 1'b1, 32'hDEAD_BEEF, 1'b0, d);
      rd_exp(A + 4, 32'hDEAD_BEEF, 0, 0, "R4 write hit readback");
      chk("R4 write hit no bus", 32'(rd_beats - r0), 0);
   endtask

   task automatic t_replacement;
      rd_exp(B, memrd(B), 4, 0, "R2 fill free way");
      rd_exp(A, memrd(A), 0, 0, "R5 touch A");
      rd_exp(C, memrd(C), 4, 0, "R5 R6 exclusive victim silent");
      rd_exp(A + 4, 32'hDEAD_BEEF, 0, 0, "R5 recent line kept");
      rd_exp(B, memrd(B), 4, 0, "R5 evicts C");
      rd_exp(C, memrd(C), 4, 4, "R6 modified victim written back");
      chk("R6 castout data in memory", memrd(A + 4), 32'hDEAD_BEEF);
      rd_exp(A + 4, 32'hDEAD_BEEF, 4, 0, "R6 refetch written data");
   endtask

   task automatic t_snoops;
      logic [31:0] d;
      int r0, w0;
      r0 = rd_beats; w0 = wr_beats;
      snoop(A + 8, 1'b1, 1'b0, "R7 snoop exclusive");
      chk("R7 no transfer", 32'(rd_beats - r0 + wr_beats - w0), 0);
      rd_exp(A + 4, 32'hDEAD_BEEF, 4, 0, "R7 line was invalidated");
      access(C + 8, 1'b1, 32'h1234_5678, 1'b0, d);
      w0 = wr_beats;
      snoop(C, 1'b1, 1'b1, "R8 snoop modified");
      chk("R8 castout beats", 32'(wr_beats - w0), 4);
      chk("R8 castout data", memrd(C + 8), 32'h1234_5678);
      snoop(C, 1'b0, 1'b0, "R8 line invalid after castout");
      snoop(32'h0000_7000, 1'b0, 1'b0, "R9 snoop miss");
   endtask

   task automatic t_busy_snoop;
      logic [31:0] d;
      fork
         access(32'h0000_4000, 1'b0, '0, 1'b0, d);
      join_none
      @(negedge clk);
      while (!bus_req) @(negedge clk);
      #1;
      snp_valid = 1'b1; snp_addr = 32'h0000_4000;
      #1;
      chk("R10 retry while busy", 32'(snp_retry), 1);
      chk("R10 no hit while busy", 32'(snp_hit), 0);
      @(posedge clk); #1 snp_valid = 1'b0;
      wait fork;
      chk("R10 access unaffected", d, memrd(32'h0000_4000));
   endtask

   task automatic t_uncached;
      logic [31:0] d;
      int u0 = unc_beats, r0 = rd_beats;
      access(32'h0000_5004, 1'b0, '0, 1'b1, d);
      chk("R11 uncached read data", d, memrd(32'h0000_5004));
      access(32'h0000_5004, 1'b0, '0, 1'b1, d);
      access(32'h0000_5008, 1'b1, 32'hAAAA_5555, 1'b1, d);
      chk("R11 single beats, no allocation", 32'(unc_beats - u0), 3);
      chk("R11 no burst", 32'(rd_beats - r0), 0);
      chk("R11 uncached write data", memrd(32'h0000_5008), 32'hAAAA_5555);
   endtask

   task automatic t_priority;
      @(negedge clk);
      core_addr = A + 4; core_we = 1'b0; core_uncached = 1'b0; core_req = 1'b1;
      snp_valid = 1'b1; snp_addr = 32'h0000_7000;
      #1;
      chk("R12 core held off by snoop", 32'(core_ack), 0);
      @(posedge clk); #1 snp_valid = 1'b0;
      #1;
      chk("R12 core acked after snoop", 32'(core_ack), 1);
      chk("R12 data", core_rdata, 32'hDEAD_BEEF);
      @(posedge clk); #1 core_req = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_fill_and_hits();
      t_replacement();
      t_snoops();
      t_busy_snoop();
      t_uncached();
      t_priority();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule